// File: doc/BRIEF.md
# Victim/Next-Victim Replacement Tracker

This block picks replacement ways for a set-associative cache at low cost. For each set it stores two way pointers. The victim pointer names the way that the next eviction will take. The next-victim pointer names the way that will become the victim after that. Every other way in the set is ordinary and has no stored status. The cache controller reports each lookup as a hit strobe with the way that hit, or as a miss strobe with the valid bits of the addressed set. The tracker then answers with the way to refill and moves its two pointers for that set.

Whenever a new next-victim is needed, it is taken from the ordinary ways by a free-running linear feedback shift register, so no recency order has to be kept. The pointers sit in a small per-set memory. All outputs are registered and take their new values on the clock edge after the strobe.

Top module: `vnv_replace_tracker`

## Requirements
- R1: While reset is high and on the first cycle after it falls, every set holds victim = way 0 and next-victim = way 1, `ptr_v` reads 0, `ptr_nv` reads 1 and `repl_vld` is 0.
- R2: A miss to a set whose `valid_mask` is all ones makes `repl_way` equal to the old victim. The old next-victim becomes the victim, and a randomly picked way becomes the next-victim.
- R3: A random pick uses the 8-bit register value r of the strobe cycle. Let k = r mod (NUM_WAYS-2). The pick is the k-th way, counting from 0 in ascending way number, among the ways that are neither the current victim nor the current next-victim. The register is seeded with 1 while reset is high. On every other clock edge it shifts left by one bit, and the new bit 0 is the XOR of bits 7, 5, 4 and 3.
- R4: A hit to the victim way moves the next-victim into the victim pointer and loads a randomly picked way into the next-victim pointer.
- R5: A hit to the next-victim way loads a randomly picked way into the next-victim pointer and leaves the victim pointer as it was.
- R6: A hit to an ordinary way leaves both pointers of the set unchanged.
- R7: A miss while some bit of `valid_mask` is 0 makes `repl_way` the lowest-numbered way whose valid bit is 0, and leaves both pointers unchanged.
- R8: `ptr_v` and `ptr_nv` show the pointers of the set on `set_idx`, as updated by that cycle's strobe, one cycle later. `repl_vld` is 1 exactly one cycle after a miss strobe, and `repl_way` is meaningful only while `repl_vld` is 1. Hit and miss strobes are never high together.
- R9: In every set, the victim and next-victim pointers always name different ways.
- R10: A strobe changes only the pointers of the set it addresses. The pointers of every other set keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_idx | input | 2 | Set addressed by this cycle's strobe or read |
| hit_vld | input | 1 | Lookup hit strobe |
| hit_way | input | 2 | Way that hit |
| miss_vld | input | 1 | Lookup miss strobe |
| valid_mask | input | 4 | Valid bit of each way in the addressed set, sampled on a miss |
| repl_vld | output | 1 | Refill way is valid this cycle |
| repl_way | output | 2 | Way to refill |
| ptr_v | output | 2 | Victim pointer of the addressed set |
| ptr_nv | output | 2 | Next-victim pointer of the addressed set |

## Verification
The assertions assume that a hit and a miss never arrive together, and one property watches for this. When an ordinary-way hit is claimed, the assertions also rely on `hit_way` being a real way of the set. The bench meets both assumptions by design. Every strobe comes from one stimulus task that selects exactly one operation per cycle, and it builds hits to the victim, the next-victim and an ordinary way from its own model of the current pointers. Idle cycles placed between strobes read back sets that were not touched.

// File: rtl/vnv_pkg.sv
package vnv_pkg;
  // Operation class of one cycle, as decoded from the strobes and pointers
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_FILL   = 3'd1,
    OP_EVICT  = 3'd2,
    OP_HIT_V  = 3'd3,
    OP_HIT_NV = 3'd4
  } vnv_op_e;
endpackage

// File: rtl/vnv_lfsr.sv
module vnv_lfsr #(
  parameter int               RW   = 8,
  parameter logic [RW-1:0]    TAPS = 8'hB8,
  parameter logic [RW-1:0]    SEED = 8'h01
) (
  input  logic          clk,
  input  logic          rst,
  output logic [RW-1:0] rnd
);
  logic fb;
  assign fb = ^(rnd & TAPS);

  always_ff @(posedge clk) begin
    if (rst) rnd <= SEED;
    else     rnd <= {rnd[RW-2:0], fb};
  end

  assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    rnd != '0);
endmodule

// File: rtl/vnv_pick.sv
module vnv_pick #(
  parameter int NUM_WAYS = 4,
  parameter int RW       = 8,
  localparam int WW      = $clog2(NUM_WAYS),
  localparam int OC      = NUM_WAYS - 2
) (
  input  logic [RW-1:0] rnd,
  input  logic [WW-1:0] ex_a,
  input  logic [WW-1:0] ex_b,
  output logic [WW-1:0] sel
);
  int k;
  int cnt;

  // k-th ascending way among those that are neither excluded pointer
  always_comb begin
    k   = int'(rnd) % OC;
    cnt = 0;
    sel = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (WW'(w) != ex_a && WW'(w) != ex_b) begin
        if (cnt == k) sel = WW'(w);
        cnt = cnt + 1;
      end
    end
  end
endmodule

// File: rtl/vnv_ptr_store.sv
module vnv_ptr_store #(
  parameter int NUM_SETS = 4,
  parameter int WW       = 2,
  localparam int SW      = $clog2(NUM_SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set_sel,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_v,
  input  logic [WW-1:0] wr_nv,
  output logic [WW-1:0] rd_v,
  output logic [WW-1:0] rd_nv
);
  logic [WW-1:0] v_mem  [NUM_SETS];
  logic [WW-1:0] nv_mem [NUM_SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        v_mem[s]  <= WW'(0);
        nv_mem[s] <= WW'(1);
      end
    end else if (wr_en) begin
      v_mem[set_sel]  <= wr_v;
      nv_mem[set_sel] <= wr_nv;
    end
  end

  assign rd_v  = v_mem[set_sel];
  assign rd_nv = nv_mem[set_sel];

  assert_store_distinct_R9: assert property (@(posedge clk) disable iff (rst)
    rd_v != rd_nv);
endmodule

// File: rtl/vnv_replace_tracker.sv
module vnv_replace_tracker
  import vnv_pkg::*;
#(
  parameter int               NUM_SETS = 4,
  parameter int               NUM_WAYS = 4,
  parameter int               RND_W    = 8,
  parameter logic [RND_W-1:0] RND_TAPS = 8'hB8,
  parameter logic [RND_W-1:0] RND_SEED = 8'h01,
  localparam int              SW       = $clog2(NUM_SETS),
  localparam int              WW       = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SW-1:0]       set_idx,
  input  logic                hit_vld,
  input  logic [WW-1:0]       hit_way,
  input  logic                miss_vld,
  input  logic [NUM_WAYS-1:0] valid_mask,
  output logic                repl_vld,
  output logic [WW-1:0]       repl_way,
  output logic [WW-1:0]       ptr_v,
  output logic [WW-1:0]       ptr_nv
);
  logic [RND_W-1:0] rnd;
  logic [WW-1:0]    rd_v, rd_nv, pick, first_inv;
  logic [WW-1:0]    nxt_v, nxt_nv;
  logic             all_valid, wr_en;
  vnv_op_e          op;

  vnv_lfsr #(.RW(RND_W), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .rnd(rnd)
  );

  vnv_pick #(.NUM_WAYS(NUM_WAYS), .RW(RND_W)) u_pick (
    .rnd(rnd), .ex_a(rd_v), .ex_b(rd_nv), .sel(pick)
  );

  vnv_ptr_store #(.NUM_SETS(NUM_SETS), .WW(WW)) u_store (
    .clk(clk), .rst(rst), .set_sel(set_idx), .wr_en(wr_en),
    .wr_v(nxt_v), .wr_nv(nxt_nv), .rd_v(rd_v), .rd_nv(rd_nv)
  );

  assign all_valid = &valid_mask;

  // Lowest-numbered invalid way, filled ahead of any eviction
  always_comb begin
    first_inv = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!valid_mask[w]) first_inv = WW'(w);
  end

  always_comb begin
    if (miss_vld)                       op = all_valid ? OP_EVICT : OP_FILL;
    else if (hit_vld && hit_way == rd_v)  op = OP_HIT_V;
    else if (hit_vld && hit_way == rd_nv) op = OP_HIT_NV;
    else                                op = OP_NONE;
  end

  always_comb begin
    nxt_v  = rd_v;
    nxt_nv = rd_nv;
    case (op)
      OP_EVICT, OP_HIT_V: begin
        nxt_v  = rd_nv;
        nxt_nv = pick;
      end
      OP_HIT_NV: nxt_nv = pick;
      default: ;
    endcase
  end

  assign wr_en = (op == OP_EVICT) || (op == OP_HIT_V) || (op == OP_HIT_NV);

  always_ff @(posedge clk) begin
    if (rst) begin
      repl_vld <= 1'b0;
      repl_way <= '0;
      ptr_v    <= WW'(0);
      ptr_nv   <= WW'(1);
    end else begin
      repl_vld <= miss_vld;
      if (miss_vld) repl_way <= all_valid ? rd_v : first_inv;
      ptr_v    <= nxt_v;
      ptr_nv   <= nxt_nv;
    end
  end

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !(hit_vld && miss_vld));

  assert_evict_R2: assert property (@(posedge clk) disable iff (rst)
    (miss_vld && all_valid) |=>
      (repl_way == $past(rd_v) && ptr_v == $past(rd_nv) &&
       ptr_nv != $past(rd_v) && ptr_nv != $past(rd_nv)));

  assert_hit_v_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && !miss_vld && hit_way == rd_v) |=>
      (ptr_v == $past(rd_nv) && ptr_nv != $past(rd_v)));

  assert_hit_nv_R5: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && !miss_vld && hit_way == rd_nv) |=>
      (ptr_v == $past(rd_v) && ptr_nv != $past(rd_nv) && ptr_nv != $past(rd_v)));

  assert_hit_o_R6: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && !miss_vld && hit_way != rd_v && hit_way != rd_nv) |=>
      (ptr_v == $past(rd_v) && ptr_nv == $past(rd_nv)));

  assert_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (miss_vld && !all_valid) |=>
      (ptr_v == $past(rd_v) && ptr_nv == $past(rd_nv) && repl_vld));

  assert_out_distinct_R9: assert property (@(posedge clk) disable iff (rst)
    ptr_v != ptr_nv);
endmodule

// File: tb/test_vnv_replace_tracker.sv
module test_vnv_replace_tracker;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] set_idx;
  logic       hit_vld;
  logic [1:0] hit_way;
  logic       miss_vld;
  logic [3:0] valid_mask;
  logic       repl_vld;
  logic [1:0] repl_way;
  logic [1:0] ptr_v;
  logic [1:0] ptr_nv;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  int         mv  [4];
  int         mnv [4];
  logic [7:0] mlfsr;

  always #10 clk = ~clk;

  vnv_replace_tracker i_vnv_replace_tracker (
    .clk(clk), .rst(rst), .set_idx(set_idx), .hit_vld(hit_vld),
    .hit_way(hit_way), .miss_vld(miss_vld), .valid_mask(valid_mask),
    .repl_vld(repl_vld), .repl_way(repl_way), .ptr_v(ptr_v), .ptr_nv(ptr_nv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pick_way(input logic [7:0] r, input int a, input int b);
    int k, c;
    k = int'(r) % 2;
    c = 0;
    for (int w = 0; w < 4; w++)
      if (w != a && w != b) begin
        if (c == k) return w;
        c++;
      end
    return 0;
  endfunction

  // op: 0 idle, 1 miss, 2 hit
  task automatic cyc(input int s, input int op, input int hw, input logic [3:0] mask);
    int ov, onv, ev, env, erep, p, other;
    string tag;
    ov  = mv[s];
    onv = mnv[s];
    p   = pick_way(mlfsr, ov, onv);
    ev = ov; env = onv; erep = 0; tag = "R10";
    set_idx = 2'(s); hit_vld = (op == 2); miss_vld = (op == 1);
    hit_way = 2'(hw); valid_mask = mask;
    if (op == 1) begin
      if (mask == 4'hF) begin
        erep = ov; ev = onv; env = p; tag = "R2";
      end else begin
        for (int w = 3; w >= 0; w--) if (!mask[w]) erep = w;
        tag = "R7";
      end
    end else if (op == 2) begin
      if (hw == ov)       begin ev = onv; env = p; tag = "R4"; end
      else if (hw == onv) begin env = p; tag = "R5"; end
      else tag = "R6";
    end
    mv[s] = ev; mnv[s] = env;
    @(posedge clk);
    mlfsr = {mlfsr[6:0], ^(mlfsr & 8'hB8)};
    @(negedge clk);
    chk(int'(ptr_v) == ev, tag, int'(ptr_v), ev);
    chk(int'(ptr_nv) == env, (env == p && env != onv) ? "R3" : tag, int'(ptr_nv), env);
    chk(repl_vld == (op == 1), "R8", int'(repl_vld), int'(op == 1));
    if (op == 1) chk(int'(repl_way) == erep, tag, int'(repl_way), erep);
    chk(ptr_v != ptr_nv, "R9", int'(ptr_v), int'(ptr_nv) + 4);
    hit_vld = 0; miss_vld = 0;
    other = (s + 1) % 4;
    if (op != 0) begin
      // read back a set that the strobe did not address
      set_idx = 2'(other);
      @(posedge clk);
      mlfsr = {mlfsr[6:0], ^(mlfsr & 8'hB8)};
      @(negedge clk);
      chk(int'(ptr_v) == mv[other], "R10", int'(ptr_v), mv[other]);
      chk(int'(ptr_nv) == mnv[other], "R10", int'(ptr_nv), mnv[other]);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; set_idx = 0; hit_vld = 0; hit_way = 0; miss_vld = 0; valid_mask = 4'hF;
    for (int s = 0; s < 4; s++) begin mv[s] = 0; mnv[s] = 1; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ptr_v == 2'd0, "R1", int'(ptr_v), 0);
    chk(ptr_nv == 2'd1, "R1", int'(ptr_nv), 1);
    chk(repl_vld == 1'b0, "R1", int'(repl_vld), 0);
    rst = 0;
    mlfsr = 8'h01;
    // R1: every set starts at victim 0, next-victim 1
    for (int s = 0; s < 4; s++) cyc(s, 0, 0, 4'hF);
    // directed: R2 eviction, R4/R5/R6 hits, R7 fill with several holes
    cyc(0, 1, 0, 4'hF);
    cyc(0, 2, mv[0], 4'hF);
    cyc(0, 2, mnv[0], 4'hF);
    cyc(0, 2, 6 - mv[0] - mnv[0] - pick_way(8'h00, mv[0], mnv[0]), 4'hF);
    cyc(1, 1, 0, 4'b1010);
    cyc(1, 1, 0, 4'b0111);
    cyc(1, 1, 0, 4'b0000);
    // sweep over sets and operation classes
    for (int i = 0; i < 600; i++) begin
      int s, sel, ow;
      logic [3:0] m;
      s   = (i * 3 + i / 5) % 4;
      sel = (i * 7 + i / 3) % 6;
      ow  = 0;
      for (int w = 3; w >= 0; w--) if (w != mv[s] && w != mnv[s]) ow = w;
      m = 4'hF & ~(4'b1 << ((i / 2) % 4));
      if (i % 11 == 0) m = m & ~(4'b1 << ((i / 7) % 4));
      case (sel)
        0: cyc(s, 0, 0, 4'hF);
        1: cyc(s, 1, 0, 4'hF);
        2: cyc(s, 1, 0, m);
        3: cyc(s, 2, mv[s], 4'hF);
        4: cyc(s, 2, mnv[s], 4'hF);
        default: cyc(s, 2, ow, 4'hF);
      endcase
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule